// File: doc/BRIEF.md
# SMBus Byte-Data Host Controller

This block is a host-side controller for a two-wire system management bus. A processor talks to it through a small set of byte-wide I/O registers. The bank sits at a base address set by configuration logic, and each register answers at that base plus its own offset. To run a transfer, software first clears stale results in the status register. It then loads a target address, a command code and, for writes, a data byte. Finally it writes a control word that carries a start flag and the byte-data protocol code.

The controller drives the clock and data lines as open-drain outputs, using a parameterised quarter-bit divider. It runs either a byte-data write or a byte-data read, then sets done, target-NACK or bus-fault status. Those status bits stay set until software writes ones to them. The transfer direction comes from bit 0 of the target-address register. After a successful read, the received byte replaces data register 0.

The register port is a plain synchronous strobe interface. A write is taken in the cycle `io_wr` is high. Read data follows `io_addr` combinationally. There is no back-pressure: writes that arrive while a transfer runs are dropped, as R6 describes.

Top module: `smbus_host_ctrl`

## Requirements
- R1: Registers answer at `cfg_base` + offset: 0 status, 2 control, 3 command, 4 target address, 5 data 0. Any other offset, and any address outside `cfg_base`..`cfg_base`+7, reads 0x00 and ignores writes.
- R2: After reset every register reads 0x00 and neither bus line is driven low.
- R3: Status bit 0 reads 1 exactly while a transfer runs. Bit 1 is done, bit 2 is target NACK and bit 3 is bus fault. Bits 7:4 read 0. At most one result bit is raised per transfer.
- R4: Writing status clears each of bits 3:1 written as 1 and leaves bits written as 0 unchanged. Writing 0xFF clears all results.
- R5: A control write starts a transfer only when the controller is idle, bit 6 is 1 and bits 4:2 equal 3'b010. The control register reads back bits 4:2 in place, with the other bits 0, so 0x48 reads back as 0x08.
- R6: While busy, writes to control, command, target and data 0 are ignored, including a second start.
- R7: With target bit 0 = 0, the controller sends START, target with the write bit, command, data 0 and then STOP. It checks an ACK after each byte and sets done at the end.
- R8: With target bit 0 = 1, the controller sends START, target with the write bit, command, a repeated START and target with the read bit. It then receives one byte, answers it with NACK and sends STOP. The received byte goes into data 0 and done is set.
- R9: A missing ACK ends the transfer with STOP and sets NACK (bit 2), not done. Busy clears, and data 0 keeps its old value.
- R10: If SDA reads low while the controller releases it for a transmitted data bit, the controller releases both lines, goes idle and sets bus fault (bit 3).
- R11: If SCL stays low for `TO_CYC` cycles while the controller waits for it to rise, the controller releases the bus, goes idle and sets bus fault.
- R12: Within a byte, consecutive SCL rising edges are 4*`QTR_CYC` clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | AW | Base address of the register bank |
| io_addr | input | AW | Register access address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for `io_addr` |
| scl_in | input | 1 | Sensed level of the clock line |
| sda_in | input | 1 | Sensed level of the data line |
| scl_low | output | 1 | 1 pulls the clock line low |
| sda_low | output | 1 | 1 pulls the data line low |

## Verification
The checks assume `QTR_CYC` is at least 2, so quarter ticks never fall on adjacent cycles. They also assume the target changes SDA only while SCL is low, so the controller never sees a false START or STOP in the middle of a byte. The bench slave follows that rule. It reacts to clock edges one cycle after it sees them, and it only disturbs the lines through the explicit forcing knobs used for the collision and timeout cases. Register accesses in the bench are single-cycle strobes, and the base address changes only while the controller is idle.

// File: rtl/smbh_pkg.sv
`timescale 1ns/1ps
package smbh_pkg;
  typedef enum logic [2:0] {
    K_IDLE, K_START, K_BYTE, K_RSTART, K_STOP
  } seg_kind_e;

  localparam logic [2:0] OFF_STATUS = 3'd0;
  localparam logic [2:0] OFF_CTL    = 3'd2;
  localparam logic [2:0] OFF_CMD    = 3'd3;
  localparam logic [2:0] OFF_TGT    = 3'd4;
  localparam logic [2:0] OFF_DATA0  = 3'd5;

  localparam int          CTL_GO_BIT      = 6;
  localparam logic [2:0]  PROTO_BYTE_DATA = 3'b010;

  // Segment order: write = START,B,B,B,STOP ; read = START,B,B,RSTART,B,B(rx),STOP
  function automatic seg_kind_e kind_of(input logic [2:0] s, input logic rd);
    if (s == 3'd0)                   return K_START;
    if (s == (rd ? 3'd6 : 3'd4))     return K_STOP;
    if (rd && s == 3'd3)             return K_RSTART;
    return K_BYTE;
  endfunction

  function automatic logic [7:0] byte_for(input logic [2:0] s, input logic [7:0] tgt,
                                          input logic [7:0] cmd, input logic [7:0] wd);
    case (s)
      3'd1:    return {tgt[7:1], 1'b0};
      3'd2:    return cmd;
      3'd3:    return wd;
      3'd4:    return {tgt[7:1], 1'b1};
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/smbh_qdiv.sv
`timescale 1ns/1ps
module smbh_qdiv #(
  parameter int QTR_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q == CW'(QTR_CYC - 1)) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tick  <= 1'b0;
    end
  end

  // R12: ticks are spaced, never back to back
  a_r12_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/smbh_regs.sv
`timescale 1ns/1ps
module smbh_regs import smbh_pkg::*; #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] io_addr,
  input  logic          io_wr,
  input  logic [7:0]    io_wdata,
  output logic [7:0]    io_rdata,
  input  logic          busy_i,
  input  logic          fin_done,
  input  logic          fin_nack,
  input  logic          fin_fault,
  input  logic          rx_load,
  input  logic [7:0]    rx_data,
  output logic          go,
  output logic [7:0]    tgt_q,
  output logic [7:0]    cmd_q,
  output logic [7:0]    data0_q
);
  logic [AW-1:0] off;
  logic          hit;
  logic [2:0]    sel;
  logic [2:0]    proto_q;
  logic          st_done, st_nack, st_fault;
  logic          wr_st, wr_ctl, wr_cmd, wr_tgt, wr_d0;

  assign off    = io_addr - cfg_base;
  assign hit    = (off[AW-1:3] == '0);
  assign sel    = off[2:0];
  assign wr_st  = io_wr && hit && sel == OFF_STATUS;
  assign wr_ctl = io_wr && hit && sel == OFF_CTL   && !busy_i;
  assign wr_cmd = io_wr && hit && sel == OFF_CMD   && !busy_i;
  assign wr_tgt = io_wr && hit && sel == OFF_TGT   && !busy_i;
  assign wr_d0  = io_wr && hit && sel == OFF_DATA0 && !busy_i;
  assign go     = wr_ctl && io_wdata[CTL_GO_BIT] && io_wdata[4:2] == PROTO_BYTE_DATA;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      proto_q <= '0; cmd_q <= '0; tgt_q <= '0; data0_q <= '0;
      st_done <= 1'b0; st_nack <= 1'b0; st_fault <= 1'b0;
    end else begin
      if (wr_ctl) proto_q <= io_wdata[4:2];
      if (wr_cmd) cmd_q   <= io_wdata;
      if (wr_tgt) tgt_q   <= io_wdata;
      if (rx_load)    data0_q <= rx_data;
      else if (wr_d0) data0_q <= io_wdata;
      // result bits: set wins over a same-cycle clear
      st_done  <= fin_done  || (st_done  && !(wr_st && io_wdata[1]));
      st_nack  <= fin_nack  || (st_nack  && !(wr_st && io_wdata[2]));
      st_fault <= fin_fault || (st_fault && !(wr_st && io_wdata[3]));
    end
  end

  always_comb begin
    io_rdata = 8'h00;
    if (hit) begin
      case (sel)
        OFF_STATUS: io_rdata = {4'b0000, st_fault, st_nack, st_done, busy_i};
        OFF_CTL:    io_rdata = {3'b000, proto_q, 2'b00};
        OFF_CMD:    io_rdata = cmd_q;
        OFF_TGT:    io_rdata = tgt_q;
        OFF_DATA0:  io_rdata = data0_q;
        default:    io_rdata = 8'h00;
      endcase
    end
  end

  // R6: settings frozen while a transfer runs
  a_r6_frozen_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> ($stable(tgt_q) && $stable(cmd_q) && $stable(proto_q)));
  // R9: a result is only reported as the transfer stops being busy
  a_r9_result_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_done || fin_nack || fin_fault) |-> !busy_i);
  // R8: received data only lands on a successful completion
  a_r8_load_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |-> fin_done);
endmodule

// File: rtl/smbh_engine.sv
`timescale 1ns/1ps
module smbh_engine import smbh_pkg::*; #(
  parameter int TO_CYC = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       go,
  input  logic [7:0] tgt,
  input  logic [7:0] cmd,
  input  logic [7:0] wdata,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       busy_o,
  output logic       fin_done,
  output logic       fin_nack,
  output logic       fin_fault,
  output logic       rx_load,
  output logic [7:0] rx_data,
  output logic       scl_low_o,
  output logic       sda_low_o
);
  localparam int TW = $clog2(TO_CYC + 1);

  seg_kind_e   kind_q;
  logic [2:0]  seg_q;
  logic [1:0]  q_q;
  logic [3:0]  bi_q;
  logic [7:0]  sh_q, rx_q;
  logic        rd_q, nack_q;
  logic [TW-1:0] wait_q;
  logic        scl_rel, sda_rel, is_rx, hold, step, timeout, coll, ack_miss, sample;

  assign busy_o  = (kind_q != K_IDLE);
  assign is_rx   = rd_q && seg_q == 3'd5;
  assign hold    = (q_q == 2'd1) && !scl_in;
  assign timeout = busy_o && hold && wait_q == TW'(TO_CYC - 1);
  assign step    = tick && busy_o && !hold;
  assign sample  = step && kind_q == K_BYTE && q_q == 2'd1;
  assign coll    = sample && !is_rx && bi_q != 4'd8 && sh_q[7] && !sda_in;
  assign ack_miss = sample && !is_rx && bi_q == 4'd8 && sda_in;
  assign rx_data = rx_q;

  always_comb begin
    scl_rel = 1'b1;
    sda_rel = 1'b1;
    case (kind_q)
      K_START:  begin sda_rel = (q_q == 2'd0);  scl_rel = (q_q <= 2'd1); end
      K_RSTART: begin sda_rel = (q_q <= 2'd1);  scl_rel = (q_q == 2'd1 || q_q == 2'd2); end
      K_STOP:   begin sda_rel = (q_q >= 2'd2);  scl_rel = (q_q != 2'd0); end
      K_BYTE:   begin
        sda_rel = (is_rx || bi_q == 4'd8) ? 1'b1 : sh_q[7];
        scl_rel = (q_q == 2'd1 || q_q == 2'd2);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q <= K_IDLE; seg_q <= '0; q_q <= '0; bi_q <= '0;
      sh_q <= '0; rx_q <= '0; rd_q <= 1'b0; nack_q <= 1'b0; wait_q <= '0;
      fin_done <= 1'b0; fin_nack <= 1'b0; fin_fault <= 1'b0; rx_load <= 1'b0;
      scl_low_o <= 1'b0; sda_low_o <= 1'b0;
    end else begin
      fin_done <= 1'b0; fin_nack <= 1'b0; fin_fault <= 1'b0; rx_load <= 1'b0;
      scl_low_o <= !scl_rel;
      sda_low_o <= !sda_rel;
      wait_q <= (busy_o && hold) ? wait_q + 1'b1 : '0;
      if (!busy_o) begin
        if (go) begin
          kind_q <= K_START; seg_q <= '0; q_q <= '0; bi_q <= '0;
          nack_q <= 1'b0; rd_q <= tgt[0];
        end
      end else if (timeout || coll) begin
        kind_q    <= K_IDLE;
        fin_fault <= 1'b1;
      end else if (step) begin
        if (ack_miss) nack_q <= 1'b1;
        if (sample && is_rx && bi_q != 4'd8) rx_q <= {rx_q[6:0], sda_in};
        if (q_q != 2'd3) begin
          q_q <= q_q + 1'b1;
        end else if (kind_q == K_BYTE && bi_q != 4'd8) begin
          bi_q <= bi_q + 1'b1;
          q_q  <= '0;
          if (!is_rx) sh_q <= {sh_q[6:0], 1'b0};
        end else if (kind_q == K_STOP) begin
          kind_q <= K_IDLE;
          if (nack_q) fin_nack <= 1'b1;
          else begin
            fin_done <= 1'b1;
            rx_load  <= rd_q;
          end
        end else if (nack_q) begin
          kind_q <= K_STOP;
          q_q    <= '0;
        end else begin
          seg_q  <= seg_q + 1'b1;
          kind_q <= kind_of(seg_q + 1'b1, rd_q);
          sh_q   <= byte_for(seg_q + 1'b1, tgt, cmd, wdata);
          bi_q   <= '0;
          q_q    <= '0;
        end
      end
    end
  end

  // R5: a start only reaches an idle sequencer
  a_r5_go_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy_o);
  // R3: one result per transfer
  a_r3_single_result: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fin_done, fin_nack, fin_fault}));
  // R10: an idle controller leaves both lines released
  a_r10_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(!busy_o)) |-> (!scl_low_o && !sda_low_o));
  // R11: a stalled SCL never waits past the limit
  a_r11_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (wait_q < TW'(TO_CYC)));
endmodule

// File: rtl/smbus_host_ctrl.sv
`timescale 1ns/1ps
module smbus_host_ctrl #(
  parameter int AW      = 16,
  parameter int QTR_CYC = 4,
  parameter int TO_CYC  = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] io_addr,
  input  logic          io_wr,
  input  logic [7:0]    io_wdata,
  output logic [7:0]    io_rdata,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_low,
  output logic          sda_low
);
  logic       busy, go, tick;
  logic       fin_done, fin_nack, fin_fault, rx_load;
  logic [7:0] rx_data, tgt, cmd, data0;

  smbh_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .io_addr(io_addr),
    .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .busy_i(busy), .fin_done(fin_done), .fin_nack(fin_nack), .fin_fault(fin_fault),
    .rx_load(rx_load), .rx_data(rx_data), .go(go),
    .tgt_q(tgt), .cmd_q(cmd), .data0_q(data0)
  );

  smbh_qdiv #(.QTR_CYC(QTR_CYC)) u_qdiv (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
  );

  smbh_engine #(.TO_CYC(TO_CYC)) u_engine (
    .clk(clk), .rst_n(rst_n), .tick(tick), .go(go),
    .tgt(tgt), .cmd(cmd), .wdata(data0),
    .scl_in(scl_in), .sda_in(sda_in), .busy_o(busy),
    .fin_done(fin_done), .fin_nack(fin_nack), .fin_fault(fin_fault),
    .rx_load(rx_load), .rx_data(rx_data),
    .scl_low_o(scl_low), .sda_low_o(sda_low)
  );
endmodule

// File: tb/smbus_host_ctrl_bench.sv
`timescale 1ns/1ps
module smbus_host_ctrl_bench;
  localparam int CLK_PER = 10;
  localparam int QTR     = 4;
  localparam logic [6:0] SL_ADDR = 7'h69;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cfg_base = 16'h0500, io_addr = '0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_wdata = '0, io_rdata;
  logic        scl_low, sda_low, scl_line, sda_line;
  logic        force_scl_low = 1'b0, force_sda_low = 1'b0, sl_drv;
  int          checks = 0, failures = 0;

  always #(CLK_PER/2) clk = ~clk;

  assign scl_line = !scl_low && !force_scl_low;
  assign sda_line = !(sda_low || sl_drv || force_sda_low);

  smbus_host_ctrl #(.AW(16), .QTR_CYC(QTR), .TO_CYC(200)) u_smbus_host_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .io_addr(io_addr),
    .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .scl_in(scl_line), .sda_in(sda_line), .scl_low(scl_low), .sda_low(sda_low)
  );

  // ---------------- behavioural target ----------------
  typedef enum logic [1:0] {P_ADDR, P_CMD, P_WR, P_RD} sph_e;
  sph_e       sl_ph;
  logic       ps, pd, sl_act, sl_rw;
  logic [3:0] sl_bc, sl_ptr;
  logic [7:0] sl_sh;
  logic [7:0] sl_mem [16];

  always @(posedge clk) begin
    if (!rst_n) begin
      ps <= 1'b1; pd <= 1'b1; sl_act <= 1'b0; sl_rw <= 1'b0; sl_bc <= '0;
      sl_ptr <= '0; sl_sh <= '0; sl_drv <= 1'b0; sl_ph <= P_ADDR;
      for (int i = 0; i < 16; i++) sl_mem[i] <= '0;
    end else begin
      ps <= scl_line; pd <= sda_line;
      if (ps && scl_line && pd && !sda_line) begin
        sl_act <= 1'b1; sl_bc <= '0; sl_ph <= P_ADDR; sl_drv <= 1'b0;
      end else if (ps && scl_line && !pd && sda_line) begin
        sl_act <= 1'b0; sl_drv <= 1'b0;
      end else if (sl_act && !ps && scl_line) begin
        if (sl_ph != P_RD && sl_bc < 4'd8) sl_sh <= {sl_sh[6:0], sda_line};
        sl_bc <= sl_bc + 1'b1;
      end else if (sl_act && ps && !scl_line) begin
        if (sl_bc == 4'd8) begin
          case (sl_ph)
            P_RD:   sl_drv <= 1'b0;
            P_ADDR: if (sl_sh[7:1] == SL_ADDR) begin sl_drv <= 1'b1; sl_rw <= sl_sh[0]; end
                    else sl_act <= 1'b0;
            P_CMD:  begin sl_ptr <= sl_sh[3:0]; sl_drv <= 1'b1; end
            default: begin sl_mem[sl_ptr] <= sl_sh; sl_drv <= 1'b1; end
          endcase
        end else if (sl_bc == 4'd9) begin
          sl_bc <= '0; sl_drv <= 1'b0;
          if (sl_ph == P_ADDR) begin
            if (sl_rw) begin sl_ph <= P_RD; sl_drv <= !sl_mem[sl_ptr][7]; end
            else sl_ph <= P_CMD;
          end else if (sl_ph == P_CMD) sl_ph <= P_WR;
        end else if (sl_ph == P_RD && sl_bc != 4'd0) begin
          sl_drv <= !sl_mem[sl_ptr][3'(7 - int'(sl_bc))];
        end
      end
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct { logic [7:0] exp; string req; } item_t;
  item_t sb[$];
  logic  rd_chk = 1'b0;

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rd_chk && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      chk({8'h00, io_rdata}, {8'h00, it.exp}, it.req);
    end
  end

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1 io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk); #1 io_wr = 1'b0;
  endtask

  task automatic peek(input logic [15:0] a, output logic [7:0] d);
    @(posedge clk); #1 io_addr = a;
    @(negedge clk); d = io_rdata;
  endtask

  task automatic expect_reg(input logic [15:0] a, input logic [7:0] e, input string req);
    sb.push_back('{exp: e, req: req});
    @(posedge clk); #1 io_addr = a; rd_chk = 1'b1;
    @(negedge clk); #1 rd_chk = 1'b0;
  endtask

  task automatic wait_result();
    logic [7:0] s;
    for (int n = 0; n < 8000; n++) begin
      peek(cfg_base, s);
      if (!s[0] && s[3:1] != 3'b000) break;
    end
  endtask

  task automatic setup(input logic [7:0] t, input logic [7:0] c, input logic [7:0] d);
    bus_wr(cfg_base + 0, 8'hFF);
    bus_wr(cfg_base + 4, t);
    bus_wr(cfg_base + 3, c);
    bus_wr(cfg_base + 5, d);
  endtask

  initial begin
    #(CLK_PER * 150000);
    failures++; checks++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cyc, r2, r3, nr;
    logic prev;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    // R2 reset state
    expect_reg(16'h0500, 8'h00, "R2 status after reset");
    expect_reg(16'h0502, 8'h00, "R2 control after reset");
    expect_reg(16'h0505, 8'h00, "R2 data0 after reset");
    chk({15'h0, scl_line & sda_line}, 16'h1, "R2 lines released");

    // R7 write transfer with R12 timing and R6 busy writes
    setup(8'hD2, 8'h05, 8'hA5);
    bus_wr(16'h0502, 8'h48);
    expect_reg(16'h0500, 8'h01, "R3 busy during transfer");
    cyc = 0; nr = 0; prev = scl_line; r2 = 0; r3 = 0;
    while (nr < 3 && cyc < 2000) begin
      @(negedge clk); cyc++;
      if (!prev && scl_line) begin
        nr++;
        if (nr == 2) r2 = cyc;
        if (nr == 3) r3 = cyc;
      end
      prev = scl_line;
    end
    chk(16'(r3 - r2), 16'(4 * QTR), "R12 SCL rise spacing");
    bus_wr(16'h0505, 8'h11);
    bus_wr(16'h0503, 8'h77);
    bus_wr(16'h0502, 8'h48);
    wait_result();
    expect_reg(16'h0500, 8'h02, "R7 done after write");
    chk({8'h0, sl_mem[5]}, 16'h00A5, "R7 target received data");
    expect_reg(16'h0505, 8'hA5, "R6 data0 write while busy ignored");
    expect_reg(16'h0503, 8'h05, "R6 command write while busy ignored");
    expect_reg(16'h0502, 8'h08, "R5 control readback");
    // R4 clear semantics
    bus_wr(16'h0500, 8'h00);
    expect_reg(16'h0500, 8'h02, "R4 zero write keeps done");
    bus_wr(16'h0500, 8'hFF);
    expect_reg(16'h0500, 8'h00, "R4 ones clear all");

    // R8 read back
    setup(8'hD3, 8'h05, 8'h00);
    bus_wr(16'h0502, 8'h48);
    wait_result();
    expect_reg(16'h0500, 8'h02, "R8 done after read");
    expect_reg(16'h0505, 8'hA5, "R8 data0 holds received byte");

    // second pattern
    setup(8'hD2, 8'h0A, 8'h3C);
    bus_wr(16'h0502, 8'h48);
    wait_result();
    chk({8'h0, sl_mem[10]}, 16'h003C, "R7 second write pattern");
    setup(8'hD3, 8'h0A, 8'h00);
    bus_wr(16'h0502, 8'h48);
    wait_result();
    expect_reg(16'h0505, 8'h3C, "R8 second read pattern");

    // R5 rejected starts
    bus_wr(16'h0500, 8'hFF);
    bus_wr(16'h0502, 8'h40);
    repeat (60) @(posedge clk);
    expect_reg(16'h0500, 8'h00, "R5 wrong protocol code no start");
    bus_wr(16'h0502, 8'h08);
    repeat (60) @(posedge clk);
    expect_reg(16'h0500, 8'h00, "R5 no start bit no start");

    // R9 NACK on unknown target, read direction keeps data0
    setup(8'hA1, 8'h02, 8'h3C);
    bus_wr(16'h0502, 8'h48);
    wait_result();
    expect_reg(16'h0500, 8'h04, "R9 nack status");
    expect_reg(16'h0505, 8'h3C, "R9 data0 kept");
    chk({15'h0, scl_line & sda_line}, 16'h1, "R9 bus released after nack");
    bus_wr(16'h0500, 8'h02);
    expect_reg(16'h0500, 8'h04, "R4 clearing done leaves nack");
    bus_wr(16'h0500, 8'h04);
    expect_reg(16'h0500, 8'h00, "R4 nack cleared");

    // R10 collision
    setup(8'hD2, 8'h01, 8'h55);
    force_sda_low = 1'b1;
    bus_wr(16'h0502, 8'h48);
    wait_result();
    force_sda_low = 1'b0;
    expect_reg(16'h0500, 8'h08, "R10 collision fault");
    chk({15'h0, scl_line & sda_line}, 16'h1, "R10 lines released");

    // R11 timeout
    setup(8'hD2, 8'h01, 8'h55);
    force_scl_low = 1'b1;
    bus_wr(16'h0502, 8'h48);
    wait_result();
    force_scl_low = 1'b0;
    expect_reg(16'h0500, 8'h08, "R11 timeout fault");
    chk({15'h0, scl_line & sda_line}, 16'h1, "R11 lines released");

    // R1 decode at a moved base
    bus_wr(16'h0500, 8'hFF);
    cfg_base = 16'h0A40;
    expect_reg(16'h0A44, 8'hD2, "R1 target at new base");
    expect_reg(16'h0504, 8'h00, "R1 old base not decoded");
    bus_wr(16'h0A41, 8'h99);
    expect_reg(16'h0A41, 8'h00, "R1 unused offset reads zero");
    expect_reg(16'h0A47, 8'h00, "R1 offset 7 reads zero");
    bus_wr(16'h0505, 8'h77);
    expect_reg(16'h0A45, 8'h55, "R1 write outside window ignored");
    setup(8'hD3, 8'h05, 8'h00);
    bus_wr(16'h0A42, 8'h48);
    wait_result();
    expect_reg(16'h0A45, 8'hA5, "R1 transfer at new base");

    repeat (5) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule